// File: doc/BRIEF.md
# Ping-Pong DMA Channel Sequencer

This block sequences a single peripheral DMA channel across two buffer descriptors used alternately. Software programs each descriptor with a start address and a byte count. While the active descriptor holds bytes, every transfer grant moves its address forward and its count down by the granted transfer width. When that descriptor is finished, the channel switches to the other one. The bus cycle itself happens elsewhere; this block only sees a one-cycle grant per completed transfer.

A single bidirectional end-of-transfer pin serves one of two roles, chosen by a mode bit. In terminal-count mode the pin is driven and pulses together with the last transfer of a descriptor. In early-stop mode the pin is an input, and a peripheral raising it retires the active descriptor at once. Either way, retiring a descriptor while the other holds bytes raises the next-buffer interrupt and keeps the channel going. Retiring with nothing left to switch to raises the completion interrupt and freezes the channel until software clears it.

Top module: `dma_pingpong_seq`

## Requirements
- R1: During and after reset, cur_addr, cur_count, active_buf, irq_done, irq_nfb, pin_out and pin_oe are all 0 (early-stop mode, descriptor 0 selected).
- R2: A write with cfg_addr 0/2 loads the start address of descriptor 0/1, 1/3 loads its byte count, 4 sets the mode from cfg_wdata[0] (1 = terminal-count output, 0 = early-stop input); the effect shows on the outputs one cycle later.
- R3: A grant on a running descriptor adds the width to its address and subtracts it from its count, where xfer_size 0, 1, 2 and 3 mean 1, 2, 4 and 4 bytes.
- R4: A grant whose width is at least the remaining count is the final transfer: the count becomes 0, and in terminal-count mode pin_out is high for exactly that grant cycle; pin_oe equals the mode bit.
- R5: In early-stop mode, pin_in high while a descriptor runs retires it in that cycle with its count cleared and any grant in that cycle unperformed; in terminal-count mode pin_in has no effect.
- R6: Retiring a descriptor toggles active_buf; if the other descriptor holds a nonzero count, irq_nfb is set and irq_done is not.
- R7: Retiring with the other descriptor's count at 0 sets irq_done; while irq_done is high, grants and pin_in change nothing.
- R8: A write to cfg_addr 5 clears irq_done where cfg_wdata[0] is 1 and irq_nfb where cfg_wdata[1] is 1; a set in the same cycle wins over the clear.
- R9: A descriptor is valid only while its count is nonzero; writing a count of 0 leaves it invalid, and grants to an invalid active descriptor are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | AW (32) | Configuration write data |
| xfer_grant | input | 1 | One transfer completed this cycle |
| xfer_size | input | 2 | Width code of the granted transfer |
| pin_in | input | 1 | End-of-transfer pin, input side |
| pin_out | output | 1 | End-of-transfer pin, output side (terminal count) |
| pin_oe | output | 1 | Output enable of the end-of-transfer pin |
| irq_done | output | 1 | Completion interrupt, sticky |
| irq_nfb | output | 1 | Next-buffer interrupt, sticky |
| active_buf | output | 1 | Index of the active descriptor |
| cur_addr | output | AW (32) | Current address of the active descriptor |
| cur_count | output | CW (16) | Remaining bytes of the active descriptor |

## Verification
The terminal-count pulse is combinational with the grant, so it is sampled in the same cycle, after the inputs settle and before the rising edge. Addresses, counts, the active index and both interrupts are registered and change at the first edge after the stimulus, so each expected value is queued when the stimulus is applied and compared shortly after that one edge. A reference model built from the requirements computes every queued value, including the same-cycle cases of grant with early stop and of set with clear.

// File: rtl/dma_pingpong_seq.sv
module dma_pingpong_seq #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          xfer_grant,
  input  logic [1:0]    xfer_size,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq_done,
  output logic          irq_nfb,
  output logic          active_buf,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count
);
  localparam logic [2:0] A_MODE = 3'd4;
  localparam logic [2:0] A_CLR  = 3'd5;

  logic [AW-1:0] ptr [2];
  logic [CW-1:0] cnt [2];
  logic act, tc_mode, done_q, nfb_q;

  logic [2:0] step;
  assign step = (xfer_size == 2'd0) ? 3'd1 : (xfer_size == 2'd1) ? 3'd2 : 3'd4;

  wire run      = (cnt[act] != '0) && !done_q;
  wire eot      = !tc_mode && pin_in && run;
  wire go       = xfer_grant && run && !eot;
  wire last     = go && (cnt[act] <= CW'(step));
  wire retire   = eot || last;
  wire other_ok = cnt[!act] != '0;
  wire clr_wr   = cfg_we && (cfg_addr == A_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        ptr[b] <= '0;
        cnt[b] <= '0;
      end
      act     <= 1'b0;
      tc_mode <= 1'b0;
      done_q  <= 1'b0;
      nfb_q   <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (go && act == 1'(b)) begin
          ptr[b] <= ptr[b] + AW'(step);
          cnt[b] <= last ? '0 : cnt[b] - CW'(step);
        end
        if (eot && act == 1'(b)) cnt[b] <= '0;
        if (cfg_we && cfg_addr == 3'(2*b))   ptr[b] <= cfg_wdata;
        if (cfg_we && cfg_addr == 3'(2*b+1)) cnt[b] <= cfg_wdata[CW-1:0];
      end
      if (retire) act <= !act;
      if (cfg_we && cfg_addr == A_MODE) tc_mode <= cfg_wdata[0];
      if (retire && !other_ok)          done_q <= 1'b1;
      else if (clr_wr && cfg_wdata[0])  done_q <= 1'b0;
      if (retire && other_ok)           nfb_q <= 1'b1;
      else if (clr_wr && cfg_wdata[1])  nfb_q <= 1'b0;
    end
  end

  assign pin_out    = tc_mode && last;
  assign pin_oe     = tc_mode;
  assign irq_done   = done_q;
  assign irq_nfb    = nfb_q;
  assign active_buf = act;
  assign cur_addr   = ptr[act];
  assign cur_count  = cnt[act];
endmodule

// File: rtl/dma_pingpong_seq_chk.sv
module dma_pingpong_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          xfer_grant,
  input logic          pin_in,
  input logic          pin_out,
  input logic          pin_oe,
  input logic          irq_done,
  input logic          irq_nfb,
  input logic          active_buf,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] cur_count
);
  p_tc_needs_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |-> pin_oe);

  p_tc_switches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |=> active_buf != $past(active_buf));

  p_one_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(irq_done) && $rose(irq_nfb)));

  p_nfb_target_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_nfb) && !$past(cfg_we)) |-> (cur_count != '0 && active_buf != $past(active_buf)));

  p_done_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && !cfg_we) |=> ($stable(cur_count) && $stable(cur_addr) && $stable(active_buf)));

  p_count_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_grant && pin_oe && !irq_done && cur_count > CW'(4) && !cfg_we) |=> cur_count < $past(cur_count));

  p_early_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_in && !pin_oe && !irq_done && cur_count != '0 && !cfg_we) |=> active_buf != $past(active_buf));
endmodule

bind dma_pingpong_seq dma_pingpong_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .xfer_grant(xfer_grant),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_done(irq_done),
  .irq_nfb(irq_nfb), .active_buf(active_buf), .cur_addr(cur_addr),
  .cur_count(cur_count)
);

// File: tb/tb_dma_pingpong_seq.sv
module tb_dma_pingpong_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        xfer_grant = 1'b0;
  logic [1:0]  xfer_size = '0;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe, irq_done, irq_nfb, active_buf;
  logic [31:0] cur_addr;
  logic [15:0] cur_count;

  always #5 clk = ~clk;

  dma_pingpong_seq dut (.*);

  int checks = 0, failures = 0;

  typedef struct {
    logic [31:0] addr; logic [15:0] cnt;
    logic act, done, nfb, oe; string tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] m_ptr [2];
  logic [15:0] m_cnt [2];
  logic m_act = 0, m_done = 0, m_nfb = 0, m_mode = 0;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(logic we, logic [2:0] a, logic [31:0] d, logic g, logic [1:0] sz,
                     logic pin, string tag);
    int by;
    logic run, eot, go, last, oth, setd, setn;
    logic i;
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d; xfer_grant = g; xfer_size = sz; pin_in = pin;
    by   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    i    = m_act;
    run  = (m_cnt[i] != 0) && !m_done;
    eot  = !m_mode && pin && run;
    go   = g && run && !eot;
    last = go && (m_cnt[i] <= 16'(by));
    oth  = m_cnt[!i] != 0;
    setd = (eot || last) && !oth;
    setn = (eot || last) && oth;
    #4;
    chk(tag, "pin_out", 32'(pin_out), 32'(m_mode && last));
    if (go) begin
      m_ptr[i] = m_ptr[i] + 32'(by);
      m_cnt[i] = last ? 16'd0 : m_cnt[i] - 16'(by);
    end
    if (eot) m_cnt[i] = 0;
    if (eot || last) m_act = !i;
    if (we) case (a)
      3'd0: m_ptr[0] = d;
      3'd1: m_cnt[0] = d[15:0];
      3'd2: m_ptr[1] = d;
      3'd3: m_cnt[1] = d[15:0];
      3'd4: m_mode = d[0];
      default: ;
    endcase
    if (setd) m_done = 1; else if (we && a == 5 && d[0]) m_done = 0;
    if (setn) m_nfb = 1;  else if (we && a == 5 && d[1]) m_nfb = 0;
    e.addr = m_ptr[m_act]; e.cnt = m_cnt[m_act]; e.act = m_act;
    e.done = m_done; e.nfb = m_nfb; e.oe = m_mode; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "cur_addr", cur_addr, e.addr);
      chk(e.tag, "cur_count", 32'(cur_count), 32'(e.cnt));
      chk(e.tag, "active_buf", 32'(active_buf), 32'(e.act));
      chk(e.tag, "irq_done", 32'(irq_done), 32'(e.done));
      chk(e.tag, "irq_nfb", 32'(irq_nfb), 32'(e.nfb));
      chk(e.tag, "pin_oe", 32'(pin_oe), 32'(e.oe));
    end
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin m_ptr[b] = 0; m_cnt[b] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "reset addr", cur_addr, 0);
    chk("R1", "reset count", 32'(cur_count), 0);
    chk("R1", "reset flags", {27'd0, active_buf, irq_done, irq_nfb, pin_out, pin_oe}, 0);
    rst_n = 1'b1;
    // R2 programming, terminal-count mode
    cyc(1, 4, 1, 0, 0, 0, "R2");
    cyc(1, 0, 32'h1000, 0, 0, 0, "R2");
    cyc(1, 1, 8, 0, 0, 0, "R2");
    cyc(1, 2, 32'h2000, 0, 0, 0, "R2");
    cyc(1, 3, 4, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 2, 0, "R3");
    cyc(0, 0, 0, 1, 2, 0, "R4");   // final, pulse, roll to buf1, nfb
    cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(1, 5, 2, 0, 0, 0, "R8");
    cyc(0, 0, 0, 1, 0, 0, "R3");
    cyc(0, 0, 0, 1, 1, 0, "R3");
    cyc(0, 0, 0, 1, 2, 0, "R7");   // final, nothing left -> done
    cyc(0, 0, 0, 1, 2, 0, "R7");   // ignored
    cyc(1, 1, 0, 0, 0, 0, "R9");   // zero count stays invalid
    cyc(1, 5, 1, 0, 0, 0, "R8");
    cyc(0, 0, 0, 1, 2, 0, "R9");   // ignored, active invalid
    cyc(1, 1, 6, 0, 0, 0, "R9");
    cyc(0, 0, 0, 1, 1, 0, "R3");
    // early-stop mode
    cyc(1, 4, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 1, 2, 1, "R5");   // stop wins over grant, done
    cyc(0, 0, 0, 1, 0, 1, "R7");   // frozen
    cyc(1, 3, 3, 0, 0, 0, "R2");
    cyc(1, 1, 5, 0, 0, 0, "R2");
    cyc(1, 5, 1, 0, 0, 0, "R8");
    cyc(1, 5, 2, 1, 2, 0, "R8");   // final on buf1, nfb set wins over clear
    cyc(1, 4, 1, 0, 0, 0, "R5");
    cyc(0, 0, 0, 1, 0, 1, "R5");   // pin ignored in output mode
    cyc(0, 0, 0, 1, 3, 0, "R3");   // code 3 = 4 bytes, final
    cyc(0, 0, 0, 0, 0, 0, "R7");
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule